// File: doc/BRIEF.md
# Display Controller Serial Register Responder

This block is a synthesizable responder for the register side of a small display controller that is reached over a four-wire serial link. A master drives a serial clock, data toward the block and an active-low select, and the block answers on its data-out line. Each selected frame opens with a start byte. That byte carries a fixed prefix, an identity bit that must match a strap input, a register/index select bit and a read/write bit. The rest of the frame then does one of four things: it loads an 8-bit index, writes a 16-bit value to the indexed register, reads that register back, or reads a status word.

Serial inputs are brought into the system clock domain through synchronizers, and all edges are detected there. The master sets its data while the serial clock is low and samples on the rising edge. The block launches each output bit after a falling edge. The register file is held in a memory written so that it maps onto block RAM. Index 0x00 is special: reads return a fixed device code, and writes control an oscillator-run flag. Index 0x22 selects pixel-memory write mode. In that mode data words do not reach the register file and raise a one-cycle flag instead.

Top module: `disp_spi_slave`

## Requirements
- R1: A start byte is accepted only when bits 7..3 equal 0b01110 and bit 2 equals `id_strap`. Bit 1 is the register select (RS) and bit 0 is read/write (RW, 1 = read). If the byte is rejected, the rest of the frame changes no state and MISO stays 0.
- R2: With RS=0 and RW=0, the block ignores byte 1 of the frame and loads byte 2 into the index register.
- R3: With RS=1 and RW=0, bytes 1 and 2 form a 16-bit value, high byte first. The value is written to the indexed register. Later bytes in the same frame are ignored.
- R4: With RS=1 and RW=1, MISO is 0 during the start byte and then sends one dummy byte of 0x00. It then sends the indexed register's 16 bits MSB first. Each bit is valid at a rising edge of SCLK.
- R5: A read of index 0x00 returns 0x9220 with the low nibble replaced by the parameter `DEV_REV` (default 1, giving 0x9221).
- R6: A data write to index 0x00 sets the oscillator flag when the value is 0x0001 and clears it for any other value. The device code read at index 0x00 does not change.
- R7: With RS=0 and RW=1, the block sends a dummy byte of 0x00 and then the status word. Bit 15 of the status word is the oscillator flag, bit 14 is set while the index equals 0x22, bits 13..8 are 0, and bits 7..0 are the index.
- R8: While the index is 0x22, each data-write frame produces exactly one cycle of `gram_write_active` and changes no register. A read of index 0x22 returns 0x0000.
- R9: Only these indices hold a register: 0x01-0x05, 0x07-0x09, 0x0B, 0x0C, 0x10-0x13, 0x21, 0x23, 0x24, 0x30-0x39, 0x40-0x45, 0x4F, 0x56, 0x60-0x62 and 0x65. Every other index except 0x00 reads 0x0000 and ignores writes.
- R10: MISO is 0 whenever CS_N is high. Raising CS_N discards a partly received byte and restarts frame decoding at the start byte.
- R11: After synchronous reset the index is 0x00, the oscillator flag is 0, and MISO and `gram_write_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial lines are oversampled with it |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the master, idle low |
| mosi | input | 1 | Serial data from the master |
| cs_n | input | 1 | Active-low frame select |
| id_strap | input | 1 | Identity bit that the start byte must match |
| miso | output | 1 | Serial data to the master, 0 when deselected |
| gram_write_active | output | 1 | One-cycle flag per data word sent to pixel memory |

## Verification
Directed frames cover each of the four start-byte kinds. Each is followed by a status or register read, which shows whether the index, the oscillator flag or a register actually moved. Bad-prefix and wrong-identity start bytes are sent with payloads that would otherwise change state. This separates rejection from simple decoding. Frames cut off mid-byte or mid-word show that a raised select discards partial data. Index-0, index-0x22, unimplemented and out-of-range indices show the special-case paths against the plain register path. A seeded random mix of all frame kinds against a bench-side register model then checks read data and pixel-write flag counts across long sequences.

// File: rtl/disp_spi_pkg.sv
package disp_spi_pkg;

  localparam logic [4:0]  START_PREFIX = 5'b01110;
  localparam logic [7:0]  IDX_DEVCODE  = 8'h00;
  localparam logic [7:0]  IDX_PIXMEM   = 8'h22;
  localparam logic [15:0] DEVCODE_BASE = 16'h9220;
  localparam logic [15:0] OSC_START    = 16'h0001;

  typedef enum logic [2:0] {
    FR_START,
    FR_INDEX,
    FR_WDATA,
    FR_READ,
    FR_SKIP
  } frame_mode_t;

  // Decode of indices that have a storage word behind them
  function automatic logic reg_present(input logic [7:0] idx);
    logic hit;
    hit = 1'b0;
    unique case (idx[7:4])
      4'h0: hit = (idx[3:0] != 4'h0) && (idx[3:0] != 4'h6) && (idx[3:0] != 4'hA)
                  && (idx[3:0] <= 4'hC);
      4'h1: hit = (idx[3:0] <= 4'h3);
      4'h2: hit = (idx[3:0] == 4'h1) || (idx[3:0] == 4'h3) || (idx[3:0] == 4'h4);
      4'h3: hit = (idx[3:0] <= 4'h9);
      4'h4: hit = (idx[3:0] <= 4'h5) || (idx[3:0] == 4'hF);
      4'h5: hit = (idx[3:0] == 4'h6);
      4'h6: hit = (idx[3:0] <= 4'h2) || (idx[3:0] == 4'h5);
      default: hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/disp_spi_shift.sv
module disp_spi_shift #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              csn_i,
  input  logic              tx_load,
  input  logic [WORD_W-1:0] tx_word,
  output logic              sel,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_q,
  output logic              miso
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam int TX_W  = 1 + BYTE_W + WORD_W;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [2:0]        sclk_p;
  logic [1:0]        mosi_p;
  logic [1:0]        csn_p;
  logic              rise, fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sr;
  logic [TX_W-1:0]   tx_sr;
  logic              tx_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= '0;
      mosi_p <= '0;
      csn_p  <= '1;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk_i};
      mosi_p <= {mosi_p[0], mosi_i};
      csn_p  <= {csn_p[0], csn_i};
    end
  end

  assign sel  = ~csn_p[1];
  assign rise = sclk_p[1] & ~sclk_p[2];
  assign fall = ~sclk_p[1] & sclk_p[2];

  // receive side: bits arrive MSB first on rising edges
  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      bit_cnt  <= '0;
      rx_sr    <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (rise) begin
        rx_sr   <= {rx_sr[BYTE_W-2:0], mosi_p[1]};
        bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          byte_vld <= 1'b1;
          byte_q   <= {rx_sr[BYTE_W-2:0], mosi_p[1]};
        end
      end
    end
  end

  // transmit side: one guard bit, dummy byte, word; shifted on falling edges
  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      tx_sr <= '0;
      tx_on <= 1'b0;
      miso  <= 1'b0;
    end else begin
      if (tx_load) begin
        tx_sr <= {1'b0, {BYTE_W{1'b0}}, tx_word};
        tx_on <= 1'b1;
      end else if (fall) begin
        tx_sr <= {tx_sr[TX_W-2:0], 1'b0};
      end
      miso <= tx_on & tx_sr[TX_W-1];
    end
  end

  AST_MISO_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !miso); // R10
  AST_PARTIAL_DROPPED: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (bit_cnt == '0) && !byte_vld); // R10

endmodule

// File: rtl/disp_spi_regs.sv
module disp_spi_regs #(
  parameter int IDX_W  = 8,
  parameter int WORD_W = 16,
  parameter int DEPTH  = 102
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  import disp_spi_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam logic [IDX_W:0] DEPTH_L = (IDX_W+1)'(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_raw;
  logic              hit_q;
  logic              w_ok, r_ok;

  initial begin
    for (int k = 0; k < DEPTH; k++) mem[k] = '0;
  end

  assign w_ok = ({1'b0, waddr} < DEPTH_L) && reg_present(8'(waddr));
  assign r_ok = ({1'b0, raddr} < DEPTH_L) && reg_present(8'(raddr));

  always_ff @(posedge clk) begin
    if (we && w_ok) mem[waddr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    rd_raw <= mem[raddr[AW-1:0]];
    hit_q  <= r_ok;
  end

  assign rdata = hit_q ? rd_raw : '0;

endmodule

// File: rtl/disp_spi_frame.sv
module disp_spi_frame #(
  parameter int IDX_W  = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              byte_vld,
  input  logic [7:0]        byte_q,
  input  logic              id_strap,
  output logic [IDX_W-1:0]  idx_q,
  output logic              osc_q,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data,
  output logic              gram_pulse,
  output logic              rd_req,
  output logic              rd_is_reg
);
  import disp_spi_pkg::*;

  frame_mode_t mode;
  logic [1:0]  byte_no;
  logic [7:0]  hi_q;
  logic [WORD_W-1:0] word_in;

  assign word_in = WORD_W'({hi_q, byte_q});

  always_ff @(posedge clk) begin
    wr_en      <= 1'b0;
    gram_pulse <= 1'b0;
    rd_req     <= 1'b0;
    if (rst) begin
      mode      <= FR_START;
      byte_no   <= '0;
      idx_q     <= '0;
      osc_q     <= 1'b0;
      hi_q      <= '0;
      wr_data   <= '0;
      rd_is_reg <= 1'b0;
    end else if (!sel) begin
      mode    <= FR_START;
      byte_no <= '0;
    end else if (byte_vld) begin
      if (byte_no != 2'd3) byte_no <= byte_no + 2'd1;
      unique case (mode)
        FR_START: begin
          if (byte_q[7:3] == START_PREFIX && byte_q[2] == id_strap) begin
            unique case (byte_q[1:0])
              2'b00: mode <= FR_INDEX;
              2'b10: mode <= FR_WDATA;
              default: begin
                mode      <= FR_READ;
                rd_req    <= 1'b1;
                rd_is_reg <= byte_q[1];
              end
            endcase
          end else begin
            mode <= FR_SKIP;
          end
        end
        FR_INDEX: begin
          if (byte_no == 2'd2) begin
            idx_q <= IDX_W'(byte_q);
            mode  <= FR_SKIP;
          end
        end
        FR_WDATA: begin
          if (byte_no == 2'd1) begin
            hi_q <= byte_q;
          end else begin
            mode <= FR_SKIP;
            if (idx_q == IDX_W'(IDX_PIXMEM)) begin
              gram_pulse <= 1'b1;
            end else if (idx_q == IDX_W'(IDX_DEVCODE)) begin
              osc_q <= (word_in == OSC_START);
            end else begin
              wr_en   <= 1'b1;
              wr_data <= word_in;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_en, gram_pulse, rd_req})); // R8
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mode == FR_SKIP || mode == FR_READ) |=> !wr_en && !gram_pulse && $stable(idx_q) && $stable(osc_q)); // R1
  AST_READ_FROM_START: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> $past(mode) == FR_START); // R4
  AST_PIXMEM_NO_REG: assert property (@(posedge clk) disable iff (rst)
    gram_pulse |-> idx_q == IDX_W'(IDX_PIXMEM)); // R8

endmodule

// File: rtl/disp_spi_slave.sv
module disp_spi_slave #(
  parameter logic [3:0] DEV_REV   = 4'h1,
  parameter int         REG_DEPTH = 102
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic mosi,
  input  logic cs_n,
  input  logic id_strap,
  output logic miso,
  output logic gram_write_active
);
  import disp_spi_pkg::*;

  localparam int IDX_W  = 8;
  localparam int WORD_W = 16;
  localparam int PAD_W  = WORD_W - IDX_W - 2;

  logic              sel, byte_vld, tx_load;
  logic [7:0]        byte_q;
  logic [IDX_W-1:0]  idx_q;
  logic              osc_q, wr_en, rd_is_reg;
  logic [WORD_W-1:0] wr_data, rdata, status_w, devcode, tx_word;

  disp_spi_shift #(.BYTE_W(8), .WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .sclk_i(sclk), .mosi_i(mosi), .csn_i(cs_n),
    .tx_load(tx_load), .tx_word(tx_word), .sel(sel),
    .byte_vld(byte_vld), .byte_q(byte_q), .miso(miso)
  );

  disp_spi_frame #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_frame (
    .clk(clk), .rst(rst), .sel(sel), .byte_vld(byte_vld), .byte_q(byte_q),
    .id_strap(id_strap), .idx_q(idx_q), .osc_q(osc_q), .wr_en(wr_en),
    .wr_data(wr_data), .gram_pulse(gram_write_active), .rd_req(tx_load),
    .rd_is_reg(rd_is_reg)
  );

  disp_spi_regs #(.IDX_W(IDX_W), .WORD_W(WORD_W), .DEPTH(REG_DEPTH)) u_regs (
    .clk(clk), .we(wr_en), .waddr(idx_q), .wdata(wr_data),
    .raddr(idx_q), .rdata(rdata)
  );

  assign devcode  = {DEVCODE_BASE[15:4], DEV_REV};
  assign status_w = {osc_q, idx_q == IDX_W'(IDX_PIXMEM), {PAD_W{1'b0}}, idx_q};
  assign tx_word  = !rd_is_reg                      ? status_w :
                    (idx_q == IDX_W'(IDX_DEVCODE)) ? devcode  : rdata;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !miso && !gram_write_active && idx_q == '0 && !osc_q); // R11

endmodule

// File: tb/tb_disp_spi_slave.sv
module tb_disp_spi_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1, id_strap = 1'b1;
  logic miso, gram;

  int nvec = 0, nerr = 0, gcount = 0, gexp = 0;
  bit finished = 0;
  logic [15:0] mdl [256];
  logic [7:0]  midx = 8'h00;
  logic        mosc = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_spi_slave dut (
    .clk(clk), .rst(rst), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .id_strap(id_strap), .miso(miso), .gram_write_active(gram)
  );

  always @(posedge clk) if (!rst && gram) gcount <= gcount + 1;

  function automatic bit has_reg(input logic [7:0] i);
    return (i >= 8'h01 && i <= 8'h05) || (i >= 8'h07 && i <= 8'h09) ||
           i == 8'h0B || i == 8'h0C || (i >= 8'h10 && i <= 8'h13) ||
           i == 8'h21 || i == 8'h23 || i == 8'h24 ||
           (i >= 8'h30 && i <= 8'h39) || (i >= 8'h40 && i <= 8'h45) ||
           i == 8'h4F || i == 8'h56 || (i >= 8'h60 && i <= 8'h62) || i == 8'h65;
  endfunction

  function automatic logic [15:0] exp_reg(input logic [7:0] i);
    if (i == 8'h00) return 16'h9221;
    return has_reg(i) ? mdl[i] : 16'h0000;
  endfunction

  function automatic logic [15:0] exp_status();
    return {mosc, midx == 8'h22, 6'b0, midx};
  endfunction

  function automatic logic [7:0] sb(input logic rs, input logic rw);
    return {5'b01110, id_strap, rs, rw};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] tx, input int nbits, output logic [31:0] rx);
    rx = '0;
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[31-i];
      tick(HALF);
      rx = {rx[30:0], miso};
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
    tick(HALF);
    cs_n = 1'b1;
    tick(8);
  endtask

  task automatic set_index(input logic [7:0] i, input logic [7:0] pad);
    logic [31:0] rx;
    xfer({sb(1'b0, 1'b0), pad, i, 8'h00}, 24, rx);
    midx = i;
  endtask

  task automatic write_word(input logic [15:0] v);
    logic [31:0] rx;
    xfer({sb(1'b1, 1'b0), v, 8'h00}, 24, rx);
    if (midx == 8'h00) mosc = (v == 16'h0001);
    else if (midx == 8'h22) gexp++;
    else if (has_reg(midx)) mdl[midx] = v;
    chk("R8 pixel-write flag count", gcount, gexp);
  endtask

  task automatic read_reg(input string req);
    logic [31:0] rx;
    xfer({sb(1'b1, 1'b1), 24'h0}, 32, rx);
    chk(req, rx, {16'h0000, exp_reg(midx)});
  endtask

  task automatic read_status(input string req);
    logic [31:0] rx;
    xfer({sb(1'b0, 1'b1), 24'h0}, 32, rx);
    chk(req, rx, {16'h0000, exp_status()});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nvec++; nerr++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    logic [31:0] rx;
    void'($urandom(32'h5EED_C0DE));
    for (int k = 0; k < 256; k++) mdl[k] = 16'h0000;
    tick(5);
    rst = 1'b0;
    tick(3);
    // R11 reset state
    chk("R11 miso after reset", miso, 1'b0);
    chk("R11 flag after reset", gram, 1'b0);
    read_status("R11 R7 status after reset");
    // R5 device code
    read_reg("R5 device code");
    // R6 oscillator start
    write_word(16'h0001);
    read_status("R6 oscillator flag set");
    read_reg("R6 device code kept");
    write_word(16'h0005);
    read_status("R6 oscillator flag cleared");
    // R2 R3 R4 plain register
    set_index(8'h10, 8'hFF);
    read_status("R2 R7 index loaded, byte1 ignored");
    write_word(16'hA5C3);
    read_reg("R3 R4 register readback");
    xfer({sb(1'b1, 1'b0), 16'h1357, 8'hEE}, 32, rx);
    mdl[8'h10] = 16'h1357;
    read_reg("R3 trailing byte ignored");
    // R9 holes and out of range
    set_index(8'h06, 8'h00);
    write_word(16'h1234);
    read_reg("R9 unimplemented index");
    set_index(8'h70, 8'h00);
    write_word(16'hBEEF);
    read_reg("R9 out of range index");
    // R8 pixel memory
    set_index(8'h22, 8'h00);
    write_word(16'h0F0F);
    write_word(16'hF0F0);
    read_reg("R8 pixel index reads zero");
    read_status("R7 R8 pixel mode status bit");
    // R1 rejected start bytes
    set_index(8'h10, 8'h00);
    xfer({8'hF0, 8'h00, 8'h30, 8'h00}, 24, rx);
    read_status("R1 bad prefix index write ignored");
    xfer({sb(1'b1, 1'b0) ^ 8'h04, 16'hDEAD, 8'h00}, 24, rx);
    read_reg("R1 wrong identity write ignored");
    xfer({sb(1'b1, 1'b1) ^ 8'h04, 24'h0}, 32, rx);
    chk("R1 wrong identity read keeps miso low", rx, 32'h0);
    id_strap = 1'b0;
    tick(4);
    set_index(8'h11, 8'h00);
    write_word(16'h4242);
    read_reg("R1 identity strap zero accepted");
    id_strap = 1'b1;
    tick(4);
    // R10 aborted frames
    xfer({sb(1'b1, 1'b0), 24'h00FFFF}, 13, rx);
    read_reg("R10 aborted write leaves register");
    xfer(32'hA000_0000, 3, rx);
    set_index(8'h12, 8'h00);
    read_status("R10 partial byte discarded");
    chk("R10 miso idle deselected", miso, 1'b0);
    // random mix
    for (int n = 0; n < 150; n++) begin
      int op;
      op = int'($urandom % 6);
      case (op)
        0: begin
          int p;
          logic [7:0] ix;
          p = int'($urandom % 8);
          ix = (p == 0) ? 8'h00 : (p == 1) ? 8'h22 : 8'($urandom % 128);
          set_index(ix, 8'($urandom));
        end
        1, 2: write_word(16'($urandom));
        3: read_reg("R4 R9 random register read");
        4: read_status("R7 random status read");
        default: begin
          logic [7:0] b;
          b = 8'($urandom);
          if (b[7:3] == 5'b01110 && b[2] == id_strap) b[7] = 1'b1;
          xfer({b, 24'($urandom)}, 32, rx);
          chk("R1 random rejected frame miso", rx, 32'h0);
          chk("R1 random rejected frame flag", gcount, gexp);
        end
      endcase
      chk("R10 miso between frames", miso, 1'b0);
    end
    read_status("R7 final status");
    finish_run();
  end

endmodule